// File: doc/BRIEF.md
# Receive System-Side Frame Serializer

This block puts one link's received frame onto the system side as two serial streams. One carries the channel data. The other carries each channel's signaling bits. The far side of the system interface supplies the timing: a bit clock and a frame pulse. The block runs on its own fast core clock and oversamples both inputs. It then acts on the bit-clock edges that the configuration selects.

Configuration sets the following:

- the bit-clock edge that samples the frame pulse;
- the edge that updates the outputs;
- the polarity of the pulse;
- a 1.544 Mb/s frame (193 bits) or a 2.048 Mb/s frame (256 bits);
- at 2.048 Mb/s, a bit clock at one or two times the bit rate, and which of the two update edges in a bit is used;
- a delay from the pulse to the start of the output frame, given in bits plus whole channels.

Channel bytes and signaling nibbles come from a per-channel store outside the block. The block drives a channel index and reads the store combinationally in the same core cycle. The outputs are paced only by the external bit clock, so there is no valid/ready handshake at the edge and nothing can push back on the stream. The consumer must take one bit per update edge.

Top module: `rxs_serializer`

## Requirements
- R1: While `rst_n` is low, and after reset until the first output update, `sdata` and `ssig` are 0.
- R2: `cfg_fs_fall` selects the bit-clock edge that samples `fpulse`: 0 selects rising and 1 selects falling. `cfg_fp_low` selects polarity: 0 means active high. A frame restarts only on a sampling edge that sees the pulse active when the previous sampling edge saw it inactive. A pulse held over several sampling edges therefore restarts the frame once.
- R3: `cfg_upd_fall` selects the edge that updates the outputs: 0 selects rising and 1 selects falling. The first update edge at or after the edge that samples the pulse carries frame count 0. When the two edge selections differ, the pulse therefore leads the first bit by half a clock. The outputs hold between updates.
- R4: At 2.048 Mb/s (`cfg_rate_e1`=1) a frame is 256 bits. Position 8c+b carries bit b of channel c, with b=0 being `rd_data[7]` (MSB first). The byte is read from the store at the index on `rd_chan`.
- R5: At 1.544 Mb/s (`cfg_rate_e1`=0) a frame is 193 bits. Position 0 is the framing bit taken from `fbit_in`, with `ssig`=0. Position 1+8c+b carries bit b of channel c, for c from 0 to 23.
- R6: `ssig` is 0 during bits 0 to 3 of each channel slot. During bits 4 to 7 it carries `rd_sig[3]`, `rd_sig[2]`, `rd_sig[1]` and `rd_sig[0]`. It stays aligned with `sdata` under every offset.
- R7: At 2.048 Mb/s with `cfg_clk2x`=1, one bit lasts two bit-clock periods. The frame pulse is sampled on the first sampling edge of a bit. `cfg_half_sel`=0 updates on the first update edge of the bit and 1 updates on the second.
- R8: `cfg_clk2x` has no effect at 1.544 Mb/s. Every update edge advances one bit.
- R9: The offset is (8*`cfg_ch_off` + `cfg_bit_off`) mod frame length. The n-th update after a restart, counting from n=0, sends frame position (n − offset) mod frame length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | System bit clock (1x or 2x the bit rate) |
| fpulse | input | 1 | System frame pulse |
| cfg_fs_fall | input | 1 | Frame-pulse sampling edge: 0 rising, 1 falling |
| cfg_upd_fall | input | 1 | Output update edge: 0 rising, 1 falling |
| cfg_clk2x | input | 1 | Bit clock runs at twice the bit rate (2.048 Mb/s only) |
| cfg_half_sel | input | 1 | With 2x clock: 0 first, 1 second update edge of a bit |
| cfg_fp_low | input | 1 | Frame pulse active low |
| cfg_rate_e1 | input | 1 | 1: 256-bit frame, 0: 193-bit frame |
| cfg_bit_off | input | 3 | Offset, bit part |
| cfg_ch_off | input | 5 | Offset, channel part |
| fbit_in | input | 1 | Framing bit for the 193-bit frame |
| rd_chan | output | 5 | Channel index presented to the store |
| rd_data | input | 8 | Store data byte for `rd_chan` |
| rd_sig | input | 4 | Store signaling nibble for `rd_chan` |
| sdata | output | 1 | Serial data output |
| ssig | output | 1 | Serial signaling output |

## Verification
The hardest situation to reach is a frame pulse that is still active on the second sampling edge of a double-rate bit. Only the edge-qualification rule stops a second restart there, and that rule is invisible unless the pulse is stretched past one sampling edge. The bench shapes the pulse in units of bit-clock edges to create this case, with the pulse spanning both falling edges of one 2x bit. It also chooses a channel offset large enough to wrap past a 193-bit frame, so the modulo step and the position of the framing bit are both exercised.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int BITS_PER_CH = 8;
  localparam int E1_CH       = 32;
  localparam int T1_CH       = 24;
  localparam int E1_LEN      = E1_CH * BITS_PER_CH;
  localparam int T1_LEN      = T1_CH * BITS_PER_CH + 1;
  localparam int POS_W       = $clog2(E1_LEN);
  localparam int CH_W        = $clog2(E1_CH);
  localparam int BIT_W       = $clog2(BITS_PER_CH);
  localparam int SIG_W       = 4;
  localparam int SIDX_W      = $clog2(SIG_W);
endpackage

// File: rtl/rxs_edge_sense.sv
module rxs_edge_sense #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fp,
  input  logic fe_fall,
  input  logic de_fall,
  input  logic fp_low,
  output logic fe_hit,
  output logic de_hit,
  output logic fp_start
);
  logic [SYNC:0]   bsh;
  logic [SYNC-1:0] fsh;
  logic            fp_prev;
  logic            rise, fall, act;

  // bclk and fp pass through equal-depth chains so the pulse level
  // lines up with the detected edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsh     <= '0;
      fsh     <= '0;
      fp_prev <= 1'b0;
    end else begin
      bsh <= {bsh[SYNC-1:0], bclk};
      fsh <= {fsh[SYNC-2:0], fp};
      if (fe_hit) fp_prev <= act;
    end
  end

  always_comb begin
    rise     = bsh[SYNC-1] & ~bsh[SYNC];
    fall     = ~bsh[SYNC-1] & bsh[SYNC];
    fe_hit   = fe_fall ? fall : rise;
    de_hit   = de_fall ? fall : rise;
    act      = fsh[SYNC-1] ^ fp_low;
    fp_start = fe_hit & act & ~fp_prev;
  end
endmodule

// File: rtl/rxs_frame_ctr.sv
module rxs_frame_ctr
  import rxs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de_hit,
  input  logic             fp_start,
  input  logic             two_x,
  input  logic             half_sel,
  input  logic             e1,
  input  logic [BIT_W-1:0] bit_off,
  input  logic [CH_W-1:0]  ch_off,
  output logic             upd,
  output logic [POS_W-1:0] cur_pos
);
  logic             pend, ph, cur_ph, start;
  logic [POS_W-1:0] nxt, nxt_pos;
  logic [POS_W:0]   flen, off_raw, off_mod, spos_w, inc_w;

  always_comb begin
    flen    = e1 ? (POS_W+1)'(E1_LEN) : (POS_W+1)'(T1_LEN);
    off_raw = {{(POS_W+1-CH_W-BIT_W){1'b0}}, ch_off, bit_off};
    off_mod = (off_raw >= flen) ? off_raw - flen : off_raw;
    // Preload so that the counter reaches 0 after 'offset' bits.
    spos_w  = (off_mod == '0) ? '0 : flen - off_mod;
    start   = de_hit & (fp_start | pend);
    cur_ph  = start ? 1'b0 : ph;
    cur_pos = start ? spos_w[POS_W-1:0] : nxt;
    inc_w   = {1'b0, cur_pos} + 1'b1;
    nxt_pos = (inc_w >= flen) ? '0 : inc_w[POS_W-1:0];
    upd     = de_hit & (~two_x | (cur_ph == half_sel));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ph   <= 1'b0;
      nxt  <= '0;
    end else begin
      if (fp_start && !de_hit) pend <= 1'b1;
      else if (de_hit)         pend <= 1'b0;
      if (de_hit) begin
        if (two_x) begin
          ph  <= ~cur_ph;
          nxt <= cur_ph ? nxt_pos : cur_pos;
        end else begin
          ph  <= 1'b0;
          nxt <= nxt_pos;
        end
      end
    end
  end
endmodule

// File: rtl/rxs_bit_mux.sv
module rxs_bit_mux
  import rxs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd,
  input  logic                   e1,
  input  logic [POS_W-1:0]       cur_pos,
  input  logic                   fbit,
  input  logic [BITS_PER_CH-1:0] rd_data,
  input  logic [SIG_W-1:0]       rd_sig,
  output logic [CH_W-1:0]        rd_chan,
  output logic                   sdata,
  output logic                   ssig
);
  logic              fslot, dbit, sbit;
  logic [POS_W-1:0]  rel;
  logic [BIT_W-1:0]  bt, didx;
  logic [SIDX_W-1:0] sidx;

  always_comb begin
    fslot   = ~e1 & (cur_pos == '0);
    rel     = e1 ? cur_pos : cur_pos - 1'b1;
    bt      = rel[BIT_W-1:0];
    rd_chan = fslot ? '0 : rel[POS_W-1:BIT_W];
    didx    = ~bt;
    sidx    = ~bt[SIDX_W-1:0];
    dbit    = fslot ? fbit : rd_data[didx];
    sbit    = ~fslot & bt[BIT_W-1] & rd_sig[sidx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdata <= 1'b0;
      ssig  <= 1'b0;
    end else if (upd) begin
      sdata <= dbit;
      ssig  <= sbit;
    end
  end
endmodule

// File: rtl/rxs_serializer.sv
module rxs_serializer
  import rxs_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bclk,
  input  logic                   fpulse,
  input  logic                   cfg_fs_fall,
  input  logic                   cfg_upd_fall,
  input  logic                   cfg_clk2x,
  input  logic                   cfg_half_sel,
  input  logic                   cfg_fp_low,
  input  logic                   cfg_rate_e1,
  input  logic [BIT_W-1:0]       cfg_bit_off,
  input  logic [CH_W-1:0]        cfg_ch_off,
  input  logic                   fbit_in,
  output logic [CH_W-1:0]        rd_chan,
  input  logic [BITS_PER_CH-1:0] rd_data,
  input  logic [SIG_W-1:0]       rd_sig,
  output logic                   sdata,
  output logic                   ssig
);
  logic             fe_hit, de_hit, fp_start, upd, two_x;
  logic [POS_W-1:0] cur_pos;

  assign two_x = cfg_clk2x & cfg_rate_e1;

  rxs_edge_sense #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fp(fpulse),
    .fe_fall(cfg_fs_fall), .de_fall(cfg_upd_fall), .fp_low(cfg_fp_low),
    .fe_hit(fe_hit), .de_hit(de_hit), .fp_start(fp_start)
  );

  rxs_frame_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .de_hit(de_hit), .fp_start(fp_start),
    .two_x(two_x), .half_sel(cfg_half_sel), .e1(cfg_rate_e1),
    .bit_off(cfg_bit_off), .ch_off(cfg_ch_off),
    .upd(upd), .cur_pos(cur_pos)
  );

  rxs_bit_mux u_mux (
    .clk(clk), .rst_n(rst_n), .upd(upd), .e1(cfg_rate_e1),
    .cur_pos(cur_pos), .fbit(fbit_in), .rd_data(rd_data), .rd_sig(rd_sig),
    .rd_chan(rd_chan), .sdata(sdata), .ssig(ssig)
  );
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker
  import rxs_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            upd,
  input logic            de_hit,
  input logic            fp_start,
  input logic            fe_sel,
  input logic            de_sel,
  input logic            e1,
  input logic [CH_W-1:0] rd_chan,
  input logic            sdata,
  input logic            ssig
);
  assert_hold_between_updates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(sdata) && $stable(ssig)));

  assert_no_back_to_back_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  assert_short_frame_channel_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !e1) |-> (rd_chan < CH_W'(T1_CH)));

  assert_coincident_sample_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_start && de_hit) |-> (fe_sel == de_sel));
endmodule

bind rxs_serializer rxs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .de_hit(de_hit), .fp_start(fp_start),
  .fe_sel(cfg_fs_fall), .de_sel(cfg_upd_fall), .e1(cfg_rate_e1),
  .rd_chan(rd_chan), .sdata(sdata), .ssig(ssig)
);

// File: tb/tb_rxs_serializer.sv
module tb_rxs_serializer;
  import rxs_pkg::*;
  localparam int CLK_P = 10;
  localparam int HALF  = 80;

  logic clk, rst_n, bclk, fpulse;
  logic cfg_fs_fall, cfg_upd_fall, cfg_clk2x, cfg_half_sel, cfg_fp_low, cfg_rate_e1;
  logic [2:0] cfg_bit_off;
  logic [4:0] cfg_ch_off;
  logic fbit_in, sdata, ssig;
  logic [4:0] rd_chan;
  logic [7:0] rd_data;
  logic [3:0] rd_sig;
  logic [7:0] mem  [E1_CH];
  logic [3:0] sigm [E1_CH];

  assign rd_data = mem[rd_chan];
  assign rd_sig  = sigm[rd_chan];

  typedef struct { logic d; logic s; int pos; string req; } exp_t;
  exp_t q[$];
  event push_ev;
  int checks = 0, fails = 0;
  bit done = 0;

  rxs_serializer dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fpulse(fpulse),
    .cfg_fs_fall(cfg_fs_fall), .cfg_upd_fall(cfg_upd_fall), .cfg_clk2x(cfg_clk2x),
    .cfg_half_sel(cfg_half_sel), .cfg_fp_low(cfg_fp_low), .cfg_rate_e1(cfg_rate_e1),
    .cfg_bit_off(cfg_bit_off), .cfg_ch_off(cfg_ch_off), .fbit_in(fbit_in),
    .rd_chan(rd_chan), .rd_data(rd_data), .rd_sig(rd_sig), .sdata(sdata), .ssig(ssig)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Expected bit for a frame position, from R4, R5 and R6.
  task automatic ref_bit(input bit e1, input int pos, output logic d, output logic s);
    int rel, ch, bt;
    if (!e1 && pos == 0) begin
      d = fbit_in; s = 1'b0;
    end else begin
      rel = e1 ? pos : pos - 1;
      ch = rel / 8; bt = rel % 8;
      d = mem[ch][7-bt];
      s = (bt >= 4) ? sigm[ch][7-bt] : 1'b0;
    end
  endtask

  // Monitor: pops one expected item per update, samples mid-bit.
  initial begin
    exp_t e;
    forever begin
      @(push_ev);
      #(HALF - 20);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (sdata !== e.d || ssig !== e.s) begin
          fails++;
          $display("FAIL %s pos=%0d sdata=%b exp=%b ssig=%b exp=%b",
                   e.req, e.pos, sdata, e.d, ssig, e.s);
        end
      end
    end
  end

  task automatic run(input bit e1, input bit fsf, input bit upf, input bit x2,
                     input bit hs, input bit fpl, input int boff, input int choff,
                     input int pw, input string req);
    int L, epb, p0, fedges, total, off, n;
    bit two, prev, pend, ph, started;
    @(negedge clk);
    rst_n = 0;
    cfg_rate_e1 = e1; cfg_fs_fall = fsf; cfg_upd_fall = upf; cfg_clk2x = x2;
    cfg_half_sel = hs; cfg_fp_low = fpl; cfg_bit_off = 3'(boff); cfg_ch_off = 5'(choff);
    bclk = 0; fpulse = fpl;
    repeat (4) @(negedge clk);
    checks++;
    if (sdata !== 1'b0 || ssig !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset sdata=%b ssig=%b expected 0 0", sdata, ssig);
    end
    rst_n = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (sdata !== 1'b0 || ssig !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset sdata=%b ssig=%b expected 0 0", sdata, ssig);
    end
    L = e1 ? 256 : 193;
    two = x2 && e1;
    epb = two ? 4 : 2;
    off = (choff * 8 + boff) % L;
    p0 = 4 + (fsf ? 1 : 0);
    fedges = L * epb;
    total = p0 + (L + 24) * epb;
    prev = 0; pend = 0; ph = 0; n = 0; started = 0;
    for (int e = 0; e < total; e++) begin
      bit rising, inwin, fe_e, de_e, st, start, cph;
      exp_t x;
      rising = (e % 2 == 0);
      inwin = (e >= p0 && e < p0 + pw) || (e >= p0 + fedges && e < p0 + fedges + pw);
      #(HALF/2); fpulse = inwin ^ fpl;
      #(HALF/2); bclk = rising;
      fe_e = (rising == !fsf);
      de_e = (rising == !upf);
      st = 0;
      if (fe_e) begin st = inwin && !prev; prev = inwin; end
      if (de_e) begin
        start = st || pend;
        pend = 0;
        cph = start ? 1'b0 : ph;
        if (start) begin n = 0; started = 1; end
        if (started && (!two || cph == hs)) begin
          x.pos = (((n - off) % L) + L) % L;
          ref_bit(e1, x.pos, x.d, x.s);
          x.req = req;
          q.push_back(x);
          -> push_ev;
        end
        if (two) begin if (cph) n++; ph = !cph; end
        else begin n++; ph = 0; end
      end else if (st) pend = 1;
    end
    #(HALF * 2);
  endtask

  initial begin
    rst_n = 0; bclk = 0; fpulse = 0; fbit_in = 1;
    cfg_fs_fall = 0; cfg_upd_fall = 0; cfg_clk2x = 0; cfg_half_sel = 0;
    cfg_fp_low = 0; cfg_rate_e1 = 1; cfg_bit_off = 0; cfg_ch_off = 0;
    for (int c = 0; c < E1_CH; c++) begin
      mem[c]  = 8'(c * 37 + 11);
      sigm[c] = 4'(c ^ 5);
    end
    // 256-bit frame, same edges, no offset: R3 R4 R6
    run(1, 0, 0, 0, 0, 0, 0, 0, 1, "R3 R4 R6");
    // pulse ahead (rising sample, falling update), active-low, offset 2 ch + 3 bits: R2 R3 R9
    run(1, 0, 1, 0, 0, 1, 3, 2, 1, "R2 R3 R9 R6");
    // 193-bit frame, falling edges, offset wraps 245 mod 193: R5 R9
    run(0, 1, 1, 0, 0, 0, 5, 30, 1, "R5 R9 R6");
    // 193-bit frame with 2x bit set (ignored), falling sample rising update: R8 R5
    run(0, 1, 0, 1, 1, 0, 0, 0, 1, "R8 R5");
    // 2x clock, first update edge, offset 1 ch + 5 bits: R7 R9
    run(1, 0, 0, 1, 0, 0, 5, 1, 1, "R7 R9");
    // 2x clock, second update edge, pulse held over both sampling edges of a bit: R7 R2
    run(1, 1, 0, 1, 1, 0, 0, 0, 3, "R7 R2");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule